// File: doc/BRIEF.md
# Serial ADC Slave Interface Logic

This block is the digital serial front end of a 10-bit converter. It acts as a synchronous serial slave clocked by the master's serial clock. While chip select is low it samples the serial data input on each rising clock edge. It discards any zeros until the first one bit arrives, then assembles an 8-bit control byte from that bit onward. The seven bits after the leading one select channel, conversion mode and power mode; the block passes the whole byte out unchanged for the conversion source to decode.

When the byte is complete, the block requests a sample from a conversion source for one clock and raises a strobe for one clock period. On the next edge it starts shifting the 10-bit result out, MSB first, one bit per rising edge. Zeros follow the LSB until the 16-clock conversion frame ends. Every output changes just after a rising edge, so a master using clock polarity 0 and phase 0 samples on the following rising edge. Raising chip select aborts whatever is in progress at once. In this project the conversion value comes from an input port.

Top module: `sadc_serial_front`

## Requirements
- R1: While `cs_n` is low, `sdi` is sampled on each rising edge of `clk`. The control byte is assembled MSB first, and `ctrl_byte` shows all 8 received bits, bit 7 holding the first one bit, from the cycle after the edge that samples the eighth bit.
- R2: Zero bits on `sdi` before the first one bit have no effect: `strb` stays low and the first one bit becomes bit 7 of the control byte.
- R3: From the edge that completes a control byte until the conversion frame ends, `sdi` is ignored and no new control byte starts.
- R4: `strb` and `conv_req` are high for exactly one clock period, the cycle after the edge that samples the eighth control bit, and are low otherwise.
- R5: On the edge after the strobe cycle, `sdo` shows bit 9 of `conv_data`. Each later edge shows the next lower bit, down to bit 0.
- R6: After bit 0, `sdo` is 0 until the frame ends. The frame covers 16 rising edges after the strobe edge, and a start bit is accepted again from the 17th edge on.
- R7: A full-scale result code 0x3FF produces ten consecutive ones on `sdo`.
- R8: While `cs_n` is high, `sdo`, `strb` and `conv_req` are 0. Any partial control byte or frame is discarded, and the next low period begins by searching for a start bit.
- R9: After reset, `sdo`, `strb` and `conv_req` are 0 and `ctrl_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select; high aborts and idles the block |
| sdi | input | 1 | Serial data input carrying the control byte |
| conv_data | input | 10 | Result code from the conversion source |
| sdo | output | 1 | Serial result output, MSB first |
| strb | output | 1 | One-clock pulse just before the result MSB |
| conv_req | output | 1 | One-clock request to the conversion source |
| ctrl_byte | output | 8 | Last complete control byte |

## Verification
The assertions assume that `conv_data` is stable from the request cycle through the following edge, and that `cs_n` changes only away from rising clock edges. The bench drives every input at the falling edge and holds `conv_data` constant for a whole frame, so both assumptions hold. The stimulus sweeps all 1024 result codes with 0 to 3 leading zeros and varied control bytes. It fills the conversion window with ones on alternate frames and starts frames back to back. It also lowers and raises chip select in the middle of a control byte and in the middle of a result.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Receive side: searching for a start bit, or collecting control bits
  typedef enum logic [0:0] {
    RX_HUNT = 1'b0,
    RX_LOAD = 1'b1
  } rx_state_e;

endpackage

// File: rtl/sadc_ctrl_rx.sv
module sadc_ctrl_rx
  import sadc_pkg::*;
#(
  parameter int CTRL_W = 8,
  localparam int CNT_W = $clog2(CTRL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              busy,
  output logic              byte_done,
  output logic [CTRL_W-1:0] ctrl_byte
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CTRL_W - 1);

  rx_state_e         state_q, state_d;
  logic [CTRL_W-2:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    state_d   = state_q;
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    ctrl_d    = ctrl_q;
    byte_done = 1'b0;
    if (cs_n) begin
      state_d = RX_HUNT;
      sh_d    = '0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        RX_HUNT: begin
          if (!busy && sdi) begin
            state_d = RX_LOAD;
            sh_d    = {{(CTRL_W-2){1'b0}}, 1'b1};
            cnt_d   = CNT_W'(1);
          end
        end
        RX_LOAD: begin
          if (cnt_q == LAST_CNT) begin
            byte_done = 1'b1;
            ctrl_d    = {sh_q, sdi};
            state_d   = RX_HUNT;
            sh_d      = '0;
            cnt_d     = '0;
          end else begin
            sh_d  = {sh_q[CTRL_W-3:0], sdi};
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      sh_q    <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      if (byte_done) ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_byte = ctrl_q;

  // R2: a completed byte always carries the start bit in its MSB
  a_r2_msb_is_start: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> ctrl_q[CTRL_W-1]);

  // R3: no collection runs while a frame is in progress
  a_r3_no_load_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state_q == RX_HUNT));

endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq #(
  parameter int FRAME_LEN = 16,
  localparam int FC_W = $clog2(FRAME_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic byte_done,
  output logic busy,
  output logic strb,
  output logic conv_req,
  output logic load
);

  localparam logic [FC_W-1:0] LAST_FC = FC_W'(FRAME_LEN - 1);

  logic            busy_q, busy_d;
  logic [FC_W-1:0] fc_q, fc_d;
  logic            strb_q, strb_d;
  logic            req_q, req_d;

  always_comb begin
    busy_d = busy_q;
    fc_d   = fc_q;
    strb_d = 1'b0;
    req_d  = 1'b0;
    if (cs_n) begin
      busy_d = 1'b0;
      fc_d   = '0;
    end else if (byte_done) begin
      busy_d = 1'b1;
      fc_d   = '0;
      strb_d = 1'b1;
      req_d  = 1'b1;
    end else if (busy_q) begin
      if (fc_q == LAST_FC) begin
        busy_d = 1'b0;
        fc_d   = '0;
      end else begin
        fc_d = fc_q + FC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fc_q   <= '0;
      strb_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      fc_q   <= fc_d;
      strb_q <= strb_d;
      req_q  <= req_d;
    end
  end

  assign busy     = busy_q;
  assign strb     = strb_q;
  assign conv_req = req_q;
  assign load     = busy_q && (fc_q == '0) && !cs_n;

  // R4: strobe lasts one period only
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q |=> !strb_q);

  // R4: request and strobe are raised together
  a_r4_req_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q |-> req_q);

  // R6: frame stays open until its last count
  a_r6_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fc_q != LAST_FC && !cs_n) |=> busy_q);

  // R8: chip select high closes the frame
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!busy_q && !strb_q && !req_q));

endmodule

// File: rtl/sadc_result_tx.sv
module sadc_result_tx #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             load,
  input  logic             busy,
  input  logic [RES_W-1:0] conv_data,
  output logic             sdo
);

  logic [RES_W-2:0] sr_q, sr_d;
  logic             sdo_q, sdo_d;

  always_comb begin
    sr_d  = sr_q;
    sdo_d = sdo_q;
    if (cs_n) begin
      sr_d  = '0;
      sdo_d = 1'b0;
    end else if (load) begin
      sdo_d = conv_data[RES_W-1];
      sr_d  = conv_data[RES_W-2:0];
    end else if (busy) begin
      sdo_d = sr_q[RES_W-2];
      sr_d  = {sr_q[RES_W-3:0], 1'b0};
    end else begin
      sdo_d = 1'b0;
      sr_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo = sdo_q;

  // R5: the edge after a load presents the result MSB
  a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sdo_q == $past(conv_data[RES_W-1])));

  // R6: outside a frame the output is zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo_q);

endmodule

// File: rtl/sadc_serial_front.sv
module sadc_serial_front #(
  parameter int RES_W     = 10,
  parameter int CTRL_W    = 8,
  parameter int FRAME_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic [RES_W-1:0]  conv_data,
  output logic              sdo,
  output logic              strb,
  output logic              conv_req,
  output logic [CTRL_W-1:0] ctrl_byte
);

  logic rst_meta_q, rst_sync_q;
  logic byte_done, busy, load;
  logic strb_i, req_i, sdo_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sadc_ctrl_rx #(.CTRL_W(CTRL_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cs_n      (cs_n),
    .sdi       (sdi),
    .busy      (busy),
    .byte_done (byte_done),
    .ctrl_byte (ctrl_byte)
  );

  sadc_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cs_n      (cs_n),
    .byte_done (byte_done),
    .busy      (busy),
    .strb      (strb_i),
    .conv_req  (req_i),
    .load      (load)
  );

  sadc_result_tx #(.RES_W(RES_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cs_n      (cs_n),
    .load      (load),
    .busy      (busy),
    .conv_data (conv_data),
    .sdo       (sdo_i)
  );

  assign sdo      = sdo_i  & ~cs_n;
  assign strb     = strb_i & ~cs_n;
  assign conv_req = req_i  & ~cs_n;

  // R3: a byte cannot complete inside a running frame
  a_r3_no_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_sync_q)
    busy |-> !byte_done);

  // R4: a completed byte opens a frame on the next cycle
  a_r4_byte_opens_frame: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (byte_done && !cs_n) |=> (busy && strb_i));

endmodule

// File: tb/sadc_serial_front_bench.sv
`timescale 1ns/1ps
module sadc_serial_front_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic       sdi;
  logic [9:0] conv_data;
  logic       sdo, strb, conv_req;
  logic [7:0] ctrl_byte;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sadc_serial_front u_sadc_serial_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdi       (sdi),
    .conv_data (conv_data),
    .sdo       (sdo),
    .strb      (strb),
    .conv_req  (conv_req),
    .ctrl_byte (ctrl_byte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, pass one rising edge, return at next falling edge
  task automatic step(input logic d);
    sdi = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_frame(input int nz, input logic [7:0] ctrl,
                           input logic [9:0] data, input logic fill);
    conv_data = data;
    cs_n = 1'b0;
    for (int i = 0; i < nz; i++) begin
      step(1'b0);
      chk(strb == 1'b0, "R2 leading zero", strb, 0);
    end
    for (int i = 7; i >= 1; i--) begin
      step(ctrl[i]);
      chk(strb == 1'b0, "R4 strobe early", strb, 0);
    end
    step(ctrl[0]);
    chk(strb == 1'b1, "R4 strobe", strb, 1);
    chk(conv_req == 1'b1, "R4 request", conv_req, 1);
    chk(ctrl_byte == ctrl, "R1 control byte", ctrl_byte, ctrl);
    for (int k = 0; k < 16; k++) begin
      step(fill);
      if (k == 0) begin
        chk(strb == 1'b0, "R4 strobe width", strb, 0);
        chk(conv_req == 1'b0, "R4 request width", conv_req, 0);
      end else begin
        chk(strb == 1'b0, "R3 no new byte", strb, 0);
      end
      if (k < 10) begin
        if (data == 10'h3FF)
          chk(sdo == 1'b1, "R7 full scale bit", sdo, 1);
        else
          chk(sdo == data[9-k], "R5 result bit", sdo, data[9-k]);
      end else begin
        chk(sdo == 1'b0, "R6 pad zero", sdo, 0);
      end
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1;
    sdi = 1'b0;
    conv_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0, "R9 sdo", sdo, 0);
    chk(strb == 1'b0, "R9 strb", strb, 0);
    chk(conv_req == 1'b0, "R9 request", conv_req, 0);
    chk(ctrl_byte == 8'h00, "R9 control byte", ctrl_byte, 0);

    // sweep all result codes, back to back, varied zeros and fill
    for (int c = 0; c < 1024; c++) begin
      run_frame(c % 4, 8'h80 | 8'((c * 37) & 8'h7F), 10'(c), c[0]);
    end

    // start bit on the 17th edge after the strobe edge (R6)
    run_frame(0, 8'hA5, 10'h2C3, 1'b0);
    run_frame(0, 8'hFF, 10'h3FF, 1'b0);

    // abort in the middle of a result (R8)
    cs_n = 1'b1;
    step(1'b0);
    conv_data = 10'h3FF;
    cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) step(i == 7 ? 1'b1 : 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0);
    cs_n = 1'b1;
    #1;
    chk(sdo == 1'b0, "R8 sdo forced low", sdo, 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1);
      chk(sdo == 1'b0, "R8 sdo idle", sdo, 0);
      chk(strb == 1'b0, "R8 strb idle", strb, 0);
      chk(conv_req == 1'b0, "R8 request idle", conv_req, 0);
    end
    run_frame(2, 8'h9C, 10'h155, 1'b1);

    // abort in the middle of a control byte (R8)
    cs_n = 1'b1;
    step(1'b0);
    cs_n = 1'b0;
    step(1'b1); step(1'b1); step(1'b0); step(1'b1);
    cs_n = 1'b1;
    step(1'b1);
    step(1'b1);
    chk(strb == 1'b0, "R8 partial byte dropped", strb, 0);
    run_frame(0, 8'h81, 10'h0AA, 1'b0);
    run_frame(3, 8'h80, 10'h000, 1'b1);
    cs_n = 1'b1;
    step(1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule